// File: doc/BRIEF.md
# Branch Target Buffer

This block sits beside the fetch stage and answers one question every cycle: is the instruction at the current fetch address a branch that was taken the last time it ran, and if so, where does fetch go next? It holds a small direct-mapped table that contains only taken branches. Each entry pairs the upper bits of a branch address with the target that branch last went to. A lookup that hits returns the stored target as the next fetch address. A lookup that misses returns the sequential address.

A later pipeline stage reports each resolved instruction on the resolve port. The report gives the branch address, whether the instruction is a branch, the actual direction, the actual target, and whether the buffer hit when the instruction was fetched. From this report the block adds, replaces or removes an entry. In the same cycle it raises a redirect with the corrected fetch address and the number of penalty cycles, so that the fetch stage can flush the wrongly fetched instruction.

Both ports are plain. The lookup port is combinational and used every fetch cycle. The resolve port has a qualifying valid and no ready: the block accepts a resolve on every cycle and never applies back-pressure, so the producing stage never stalls on it.

Top module: `branch_target_buffer`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses.
- R2: A lookup hits when the entry selected by fetch address bits [7:2] is valid and its stored tag equals fetch address bits [31:8]. On a hit, `pred_hit` is 1 and `pred_next_pc` is the stored target, in the same cycle as the address.
- R3: On a lookup miss, `pred_hit` is 0 and `pred_next_pc` is the fetch address plus 4.
- R4: A resolve that reports a fetch miss on a taken branch writes the branch tag and actual target into its entry. It raises `redirect` with `redirect_pc` equal to the actual target and `redirect_penalty` equal to 2.
- R5: A resolve that reports a fetch hit on an instruction that is not a taken branch raises `redirect` to the branch address plus 4 with penalty 2. If the entry still holds that branch, the entry is invalidated.
- R6: A fetch hit on a taken branch whose stored target equals the actual target, and a fetch miss on an instruction that is not a taken branch, leave the table unchanged and give `redirect` 0 with penalty 0.
- R7: A fetch hit on a taken branch whose entry no longer holds that branch, or whose stored target differs from the actual target, rewrites the entry. It raises `redirect` to the actual target with penalty 2.
- R8: A lookup in the same cycle as a write to the same entry returns the entry's old contents. The new contents are seen by lookups from the next cycle on.
- R9: Two addresses with equal bits [7:2] and different bits [31:8] share one entry. Writing one of them replaces the other, and the replaced address then misses.
- R10: While `rs_valid` is 0, the resolve fields have no effect: the table is unchanged, `redirect` is 0 and the penalty is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | 32 | Address being fetched |
| pred_hit | output | 1 | Fetch address is a predicted-taken branch |
| pred_next_pc | output | 32 | Predicted next fetch address |
| rs_valid | input | 1 | Resolve report present this cycle |
| rs_pc | input | 32 | Address of the resolved instruction |
| rs_is_branch | input | 1 | Resolved instruction is a branch |
| rs_taken | input | 1 | Branch was actually taken |
| rs_target | input | 32 | Actual branch target |
| rs_hit | input | 1 | Buffer hit when this instruction was fetched |
| redirect | output | 1 | Fetch must restart at `redirect_pc` |
| redirect_pc | output | 32 | Corrected fetch address |
| redirect_penalty | output | 2 | Penalty cycles of this resolve (0 or 2) |

## Verification
Directed sequences cover each resolve case in turn: insert on a taken miss, a correct hit, a hit with a changed target, a hit that falls through, an aliasing address that evicts its neighbour, and an invalid resolve carrying junk fields. The insert case also runs a lookup of the same address in the write cycle, which separates old-contents read behaviour from write-through. A long random phase then draws fetch and resolve addresses from a small pool containing colliding indices. Its hit flags mostly agree with the table but sometimes are stale, which exercises the case where an entry changed between fetch and resolve.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef enum logic [0:0] {
    WR_FILL = 1'b0,
    WR_DROP = 1'b1
  } wr_kind_e;

  typedef struct packed {
    logic        redirect;
    logic [31:0] pc;
    logic [1:0]  penalty;
  } redir_t;
endpackage

// File: rtl/btb_store.sv
module btb_store #(
  parameter int IDX_W = 6,
  parameter int TAG_W = 24,
  parameter int PC_W  = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IDX_W-1:0]    ra_idx,
  output logic                ra_vld,
  output logic [TAG_W-1:0]    ra_tag,
  output logic [PC_W-1:0]     ra_tgt,
  input  logic [IDX_W-1:0]    rb_idx,
  output logic                rb_vld,
  output logic [TAG_W-1:0]    rb_tag,
  output logic [PC_W-1:0]     rb_tgt,
  input  logic                we,
  input  btb_pkg::wr_kind_e   wkind,
  input  logic [IDX_W-1:0]    widx,
  input  logic [TAG_W-1:0]    wtag,
  input  logic [PC_W-1:0]     wtgt
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] vld_q;
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [PC_W-1:0]  tgt_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[e] <= 1'b0;
      end else if (we && widx == IDX_W'(e)) begin
        vld_q[e] <= (wkind == btb_pkg::WR_FILL);
      end
    end

    always_ff @(posedge clk) begin
      if (we && widx == IDX_W'(e) && wkind == btb_pkg::WR_FILL) begin
        tag_q[e] <= wtag;
        tgt_q[e] <= wtgt;
      end
    end
  end

  assign ra_vld = vld_q[ra_idx];
  assign ra_tag = tag_q[ra_idx];
  assign ra_tgt = tgt_q[ra_idx];
  assign rb_vld = vld_q[rb_idx];
  assign rb_tag = tag_q[rb_idx];
  assign rb_tgt = tgt_q[rb_idx];

  // R4 / R7: a fill is visible with its tag and target one cycle later
  a_r4_fill_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wkind == btb_pkg::WR_FILL) |=>
      (vld_q[$past(widx)] && tag_q[$past(widx)] == $past(wtag)
       && tgt_q[$past(widx)] == $past(wtgt)));

  // R5: a drop leaves the entry invalid
  a_r5_drop_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wkind == btb_pkg::WR_DROP) |=> !vld_q[$past(widx)]);

  // R10: no write means no valid bit moves
  a_r10_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(vld_q));
endmodule

// File: rtl/btb_lookup.sv
module btb_lookup #(
  parameter int IDX_W = 6,
  parameter int TAG_W = 24,
  parameter int PC_W  = 32
) (
  input  logic [PC_W-1:0]  pc,
  input  logic             ent_vld,
  input  logic [TAG_W-1:0] ent_tag,
  input  logic [PC_W-1:0]  ent_tgt,
  output logic             hit,
  output logic [PC_W-1:0]  next_pc
);
  localparam int TAG_LO = IDX_W + 2;

  logic [TAG_W-1:0] pc_tag;

  always_comb begin
    pc_tag  = pc[PC_W-1:TAG_LO];
    hit     = ent_vld && (ent_tag == pc_tag);
    next_pc = hit ? ent_tgt : pc + PC_W'(4);
  end
endmodule

// File: rtl/btb_policy.sv
module btb_policy #(
  parameter int IDX_W   = 6,
  parameter int TAG_W   = 24,
  parameter int PC_W    = 32,
  parameter int PENALTY = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rs_valid,
  input  logic [PC_W-1:0]    rs_pc,
  input  logic               rs_is_branch,
  input  logic               rs_taken,
  input  logic [PC_W-1:0]    rs_target,
  input  logic               rs_hit,
  input  logic               ent_vld,
  input  logic [TAG_W-1:0]   ent_tag,
  input  logic [PC_W-1:0]    ent_tgt,
  output logic               we,
  output btb_pkg::wr_kind_e  wkind,
  output logic [IDX_W-1:0]   widx,
  output logic [TAG_W-1:0]   wtag,
  output logic [PC_W-1:0]    wtgt,
  output btb_pkg::redir_t    rd
);
  localparam int TAG_LO = IDX_W + 2;

  logic took, owns, same_tgt;

  always_comb begin
    took     = rs_is_branch && rs_taken;
    owns     = ent_vld && (ent_tag == rs_pc[PC_W-1:TAG_LO]);
    same_tgt = owns && (ent_tgt == rs_target);

    widx  = rs_pc[TAG_LO-1:2];
    wtag  = rs_pc[PC_W-1:TAG_LO];
    wtgt  = rs_target;
    we    = 1'b0;
    wkind = btb_pkg::WR_FILL;
    rd    = '{redirect: 1'b0, pc: rs_target, penalty: 2'd0};

    if (rs_valid) begin
      if (rs_hit && !took) begin
        // fell through a predicted-taken entry
        we    = owns;
        wkind = btb_pkg::WR_DROP;
        rd    = '{redirect: 1'b1, pc: rs_pc + PC_W'(4), penalty: 2'(PENALTY)};
      end else if (took && !(rs_hit && same_tgt)) begin
        // new taken branch, stale entry, or changed target
        we    = 1'b1;
        wkind = btb_pkg::WR_FILL;
        rd    = '{redirect: 1'b1, pc: rs_target, penalty: 2'(PENALTY)};
      end
    end
  end

  // R10: an absent resolve never redirects
  a_r10_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_valid |-> (!rd.redirect && !we));

  // R4: a taken branch that missed at fetch always redirects to its target
  a_r4_miss_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_hit && rs_is_branch && rs_taken) |->
      (rd.redirect && rd.pc == rs_target && we));

  // R6: penalty is charged exactly when redirecting
  a_r6_penalty_pair: assert property (@(posedge clk) disable iff (!rst_n)
    rd.redirect ? (rd.penalty == 2'(PENALTY)) : (rd.penalty == 2'd0));
endmodule

// File: rtl/branch_target_buffer.sv
module branch_target_buffer #(
  parameter int IDX_W   = 6,
  parameter int PC_W    = 32,
  parameter int PENALTY = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            pred_hit,
  output logic [PC_W-1:0] pred_next_pc,
  input  logic            rs_valid,
  input  logic [PC_W-1:0] rs_pc,
  input  logic            rs_is_branch,
  input  logic            rs_taken,
  input  logic [PC_W-1:0] rs_target,
  input  logic            rs_hit,
  output logic            redirect,
  output logic [PC_W-1:0] redirect_pc,
  output logic [1:0]      redirect_penalty
);
  localparam int TAG_LO = IDX_W + 2;
  localparam int TAG_W  = PC_W - TAG_LO;

  logic              fa_vld, rb_vld, we;
  logic [TAG_W-1:0]  fa_tag, rb_tag, wtag;
  logic [PC_W-1:0]   fa_tgt, rb_tgt, wtgt;
  logic [IDX_W-1:0]  widx;
  btb_pkg::wr_kind_e wkind;
  btb_pkg::redir_t   rd;

  btb_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .PC_W(PC_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .ra_idx(fetch_pc[TAG_LO-1:2]), .ra_vld(fa_vld), .ra_tag(fa_tag), .ra_tgt(fa_tgt),
    .rb_idx(rs_pc[TAG_LO-1:2]),    .rb_vld(rb_vld), .rb_tag(rb_tag), .rb_tgt(rb_tgt),
    .we(we), .wkind(wkind), .widx(widx), .wtag(wtag), .wtgt(wtgt)
  );

  btb_lookup #(.IDX_W(IDX_W), .TAG_W(TAG_W), .PC_W(PC_W)) u_lookup (
    .pc(fetch_pc), .ent_vld(fa_vld), .ent_tag(fa_tag), .ent_tgt(fa_tgt),
    .hit(pred_hit), .next_pc(pred_next_pc)
  );

  btb_policy #(.IDX_W(IDX_W), .TAG_W(TAG_W), .PC_W(PC_W), .PENALTY(PENALTY)) u_policy (
    .clk(clk), .rst_n(rst_n),
    .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_is_branch(rs_is_branch),
    .rs_taken(rs_taken), .rs_target(rs_target), .rs_hit(rs_hit),
    .ent_vld(rb_vld), .ent_tag(rb_tag), .ent_tgt(rb_tgt),
    .we(we), .wkind(wkind), .widx(widx), .wtag(wtag), .wtgt(wtgt), .rd(rd)
  );

  assign redirect         = rd.redirect;
  assign redirect_pc      = rd.pc;
  assign redirect_penalty = rd.penalty;

  // R3: a miss always predicts the sequential address
  a_r3_miss_seq: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_hit |-> (pred_next_pc == fetch_pc + PC_W'(4)));

  // R1: the first cycle out of reset sees an empty table
  a_r1_empty_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> !pred_hit);
endmodule

// File: tb/branch_target_buffer_test.sv
module branch_target_buffer_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] fetch_pc;
  logic        pred_hit;
  logic [31:0] pred_next_pc;
  logic        rs_valid, rs_is_branch, rs_taken, rs_hit;
  logic [31:0] rs_pc, rs_target;
  logic        redirect;
  logic [31:0] redirect_pc;
  logic [1:0]  redirect_penalty;

  int checks = 0;
  int errors = 0;

  // behavioural model: full branch address kept per slot
  bit          m_v   [64];
  logic [31:0] m_pc  [64];
  logic [31:0] m_tgt [64];

  always #5 clk = ~clk;

  branch_target_buffer uut (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
    .pred_hit(pred_hit), .pred_next_pc(pred_next_pc),
    .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_is_branch(rs_is_branch),
    .rs_taken(rs_taken), .rs_target(rs_target), .rs_hit(rs_hit),
    .redirect(redirect), .redirect_pc(redirect_pc),
    .redirect_penalty(redirect_penalty)
  );

  function automatic bit m_holds(input logic [31:0] a);
    int i = int'(a[7:2]);
    return m_v[i] && (m_pc[i][31:8] == a[31:8]);
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive one cycle, compare all outputs to the model, advance the model
  task automatic step(input string req, input logic [31:0] fpc,
                      input bit v, input logic [31:0] rpc, input bit br,
                      input bit tk, input logic [31:0] rtg, input bit rh);
    bit e_hit, e_red, took, own, same;
    logic [31:0] e_np, e_rpc;
    int ri;
    @(negedge clk);
    fetch_pc = fpc; rs_valid = v; rs_pc = rpc; rs_is_branch = br;
    rs_taken = tk; rs_target = rtg; rs_hit = rh;
    #1;
    e_hit = m_holds(fpc);
    e_np  = e_hit ? m_tgt[int'(fpc[7:2])] : fpc + 32'd4;
    ri    = int'(rpc[7:2]);
    took  = br && tk;
    own   = m_holds(rpc);
    same  = own && (m_tgt[ri] == rtg);
    e_red = 1'b0; e_rpc = 32'h0;
    if (v && rh && !took) begin
      e_red = 1'b1; e_rpc = rpc + 32'd4;
      if (own) m_v[ri] = 1'b0;
    end else if (v && took && !(rh && same)) begin
      e_red = 1'b1; e_rpc = rtg;
      m_v[ri] = 1'b1; m_pc[ri] = rpc; m_tgt[ri] = rtg;
    end
    check(req, "pred_hit", {31'd0, pred_hit}, {31'd0, e_hit});
    check(req, "pred_next_pc", pred_next_pc, e_np);
    check(req, "redirect", {31'd0, redirect}, {31'd0, e_red});
    if (e_red) check(req, "redirect_pc", redirect_pc, e_rpc);
    check(req, "redirect_penalty", {30'd0, redirect_penalty},
          e_red ? 32'd2 : 32'd0);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  localparam logic [31:0] A  = 32'h0000_1040;  // index 16
  localparam logic [31:0] B  = 32'h0000_2040;  // same index, other tag
  localparam logic [31:0] C  = 32'h0000_3100;
  localparam logic [31:0] TA = 32'h0000_8000;
  localparam logic [31:0] TB = 32'h0000_9000;

  initial begin
    for (int i = 0; i < 64; i++) begin m_v[i] = 0; m_pc[i] = 0; m_tgt[i] = 0; end
    rst_n = 1'b0; fetch_pc = 0; rs_valid = 0; rs_pc = 0; rs_is_branch = 0;
    rs_taken = 0; rs_target = 0; rs_hit = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: empty table
    step("R1", A, 0, 0, 0, 0, 0, 0);
    step("R1", C, 0, 0, 0, 0, 0, 0);
    // R4 + R8: insert A while fetching A in the same cycle (old contents)
    step("R4 R8", A, 1, A, 1, 1, TA, 0);
    // R2: now visible
    step("R2 R8", A, 0, 0, 0, 0, 0, 0);
    // R6: correct hit, and miss on non-taken instruction
    step("R6", A, 1, A, 1, 1, TA, 1);
    step("R6", C, 1, C, 1, 0, TB, 0);
    step("R3", C, 0, 0, 0, 0, 0, 0);
    // R7: target changes
    step("R7", A, 1, A, 1, 1, TB, 1);
    step("R7", A, 0, 0, 0, 0, 0, 0);
    // R9: alias B evicts A
    step("R9", B, 1, B, 1, 1, TA, 0);
    step("R9", A, 0, 0, 0, 0, 0, 0);
    step("R9", B, 0, 0, 0, 0, 0, 0);
    // R10: junk on an invalid resolve
    step("R10", B, 0, B, 1, 0, TB, 1);
    step("R10", B, 0, C, 1, 1, TB, 0);
    // R5: hit falls through, entry removed
    step("R5", B, 1, B, 1, 0, TA, 1);
    step("R5", B, 0, 0, 0, 0, 0, 0);
    // R5: stale hit on A whose slot now belongs to nobody / non-branch alias
    step("R5", A, 1, A, 0, 1, TA, 1);
    // R7: stale hit taken with entry owned by another tag
    step("R4", B, 1, B, 1, 1, TB, 0);
    step("R7", A, 1, A, 1, 1, TA, 1);
    step("R9", B, 0, 0, 0, 0, 0, 0);

    // random phase over a colliding address pool
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] fp, rp, tg;
      bit rv, rb, rt, rh;
      fp = {20'h0, 4'($urandom_range(0, 3)), 2'b01, 4'($urandom_range(0, 3)), 2'b00};
      rp = {20'h0, 4'($urandom_range(0, 3)), 2'b01, 4'($urandom_range(0, 3)), 2'b00};
      tg = {16'h0, 4'($urandom_range(0, 2)), 12'h000};
      rv = ($urandom_range(0, 3) != 0);
      rb = ($urandom_range(0, 4) != 0);
      rt = $urandom_range(0, 1) == 1;
      rh = ($urandom_range(0, 5) == 0) ? ($urandom_range(0, 1) == 1) : m_holds(rp);
      step("R2 R3 R4 R5 R6 R7 R9 R10", fp, rv, rp, rb, rt, tg, rh);
    end

    // R1: reset again clears everything
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 64; i++) m_v[i] = 0;
    step("R1", 32'h0000_1044, 0, 0, 0, 0, 0, 0);
    step("R1", 32'h0000_1144, 0, 0, 0, 0, 0, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule